// File: doc/BRIEF.md
# Translation Request Coalescer

This block sits in front of a translation lookaside buffer. Requesters present translation requests one at a time on a shared channel. Each request carries a requester ID, a virtual address, an issue timestamp and an access type. The block merges requests into groups. Requests share a group only when they agree on three things: the virtual page number, which is the address shifted right by `PAGE_SHIFT`; the time-window index, which is the timestamp divided by `WINDOW`; and the access type. Each group is later sent downstream as one probe. A probe carries the page number, a bitmask of the requester IDs that were merged into it, and the access type.

Downstream capacity is tracked with credits. At most `MAX_OUT` probes may be outstanding, and a completion count input returns credits. Each cycle the block issues up to `PROBES` pending groups, limited also by the free credits. Oldest window goes first; within one window, the group created earliest goes first. A requester whose request is accepted while no credits are free is marked stalled and is queued once. Stalled requesters are released in queue order as credits become available.

Top module: `xc_coalescer`

## Requirements
- R1: After reset, no probe is valid, no requester is stalled, no release is signalled, and `in_ready` is high.
- R2: An accepted request joins a pending, not-yet-issued group when all of the following hold: the page number matches, the window index matches, the access type matches (0 = read, 1 = write), and merging is enabled. A merge sets bit `in_port` of that group's probe mask.
- R3: Requests on the same page that differ in window index or in access type form separate groups.
- R4: While `merge_off` is 1, every accepted request creates its own group, and its probe mask has one bit set.
- R5: A group holds at most `GROUP_DEPTH` requests. A request that would exceed this starts a new group.
- R6: Pending groups issue in ascending window index, then in creation order. When several probes issue in one cycle, lane 0 carries the oldest, and the valid lanes are contiguous starting from lane 0.
- R7: Each cycle issues at most min(`PROBES`, `MAX_OUT` − outstanding) probes. Outstanding rises by the number of probes issued and falls by `done_cnt`. It never exceeds `MAX_OUT`.
- R8: `in_ready` is low only when the request matches no group and all `NUM_GROUPS` entries are occupied. A request that merges into an existing group is accepted even when every entry is occupied.
- R9: A request accepted while outstanding equals `MAX_OUT` sets the `stall_vec` bit of its requester. That requester is queued only if it is not already stalled.
- R10: In each cycle where credits are free and the stall queue is not empty, the head of the queue is released. The release raises `rel_valid` with `rel_port` for one cycle and clears that requester's `stall_vec` bit. Releases follow the order in which requesters were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_off | input | 1 | 1 disables merging |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_port | input | $clog2(NUM_PORTS) | Requester ID |
| in_vaddr | input | VA_W | Virtual address |
| in_time | input | TS_W | Issue timestamp |
| in_write | input | 1 | Access type, 1 = write |
| done_cnt | input | $clog2(MAX_OUT+1) | Completions returned this cycle |
| pr_valid | output | PROBES | Per-lane probe valid |
| pr_vpn | output | PROBES*(VA_W-PAGE_SHIFT) | Per-lane page number |
| pr_mask | output | PROBES*NUM_PORTS | Per-lane merged requester mask |
| pr_write | output | PROBES | Per-lane access type |
| stall_vec | output | NUM_PORTS | Stalled requesters |
| rel_valid | output | 1 | A requester is released this cycle |
| rel_port | output | $clog2(NUM_PORTS) | Released requester ID |

## Verification
Merging, window ordering and the capacity limit are hard to observe from the ports. A lone group issues on the cycle after it is created, so it rarely waits long enough for another request to join it. To get around this, each scenario first saturates the credits with four probes to distinct pages. Groups then pile up while nothing can issue, and these are the conditions under which merging, cross-window ordering, group overflow, a full table and stalling occur. Credits are then returned in bulk, which makes two probes issue in the same cycle and exercises the release queue while it drains.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int SEQ_W = 16;
    typedef enum logic {ACC_READ = 1'b0, ACC_WRITE = 1'b1} acc_t;
endpackage

// File: rtl/xc_first.sv
module xc_first #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xc_pick.sv
module xc_pick #(
    parameter int N  = 8,
    parameter int L  = 2,
    parameter int KW = 32,
    parameter int BW = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]          elig,
    input  logic [N-1:0][KW-1:0]  key,
    input  logic [BW-1:0]         budget,
    output logic [L-1:0]          lane_vld,
    output logic [L-1:0][IW-1:0]  lane_idx,
    output logic [N-1:0]          taken
);
    logic          found;
    logic [IW-1:0] best;

    always_comb begin
        taken    = '0;
        lane_vld = '0;
        lane_idx = '0;
        found    = 1'b0;
        best     = '0;
        for (int l = 0; l < L; l++) begin
            found = 1'b0;
            best  = '0;
            if (l < int'(budget)) begin
                for (int i = 0; i < N; i++) begin
                    if (elig[i] && !taken[i] && (!found || key[i] < key[best])) begin
                        found = 1'b1;
                        best  = IW'(i);
                    end
                end
            end
            lane_vld[l] = found;
            lane_idx[l] = best;
            if (found) taken[best] = 1'b1;
        end
    end
endmodule

// File: rtl/xc_stall_fifo.sv
module xc_stall_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_id,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t d, q;

    always_comb begin
        d = q;
        if (push) begin
            d.mem[q.wp] = push_id;
            d.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (pop) begin
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head     = q.mem[q.rp];
    assign nonempty = (q.cnt != '0);
endmodule

// File: rtl/xc_coalescer.sv
module xc_coalescer #(
    parameter int NUM_PORTS   = 8,
    parameter int VA_W        = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int TS_W        = 16,
    parameter int WINDOW      = 1,
    parameter int PROBES      = 2,
    parameter int MAX_OUT     = 4,
    parameter int NUM_GROUPS  = 8,
    parameter int GROUP_DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              merge_off,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [$clog2(NUM_PORTS)-1:0]      in_port,
    input  logic [VA_W-1:0]                   in_vaddr,
    input  logic [TS_W-1:0]                   in_time,
    input  logic                              in_write,
    input  logic [$clog2(MAX_OUT+1)-1:0]      done_cnt,
    output logic [PROBES-1:0]                 pr_valid,
    output logic [PROBES*(VA_W-PAGE_SHIFT)-1:0] pr_vpn,
    output logic [PROBES*NUM_PORTS-1:0]       pr_mask,
    output logic [PROBES-1:0]                 pr_write,
    output logic [NUM_PORTS-1:0]              stall_vec,
    output logic                              rel_valid,
    output logic [$clog2(NUM_PORTS)-1:0]      rel_port
);
    import xc_pkg::*;

    localparam int VPN_W = VA_W - PAGE_SHIFT;
    localparam int PID_W = $clog2(NUM_PORTS);
    localparam int GI_W  = $clog2(NUM_GROUPS);
    localparam int OC_W  = $clog2(MAX_OUT + 1);
    localparam int DC_W  = $clog2(GROUP_DEPTH + 1);
    localparam int KEY_W = TS_W + SEQ_W;

    typedef struct packed {
        logic                 vld;
        acc_t                 wr;
        logic [VPN_W-1:0]     vpn;
        logic [TS_W-1:0]      win;
        logic [SEQ_W-1:0]     seq;
        logic [NUM_PORTS-1:0] mask;
        logic [DC_W-1:0]      cnt;
    } group_t;

    typedef struct packed {
        group_t [NUM_GROUPS-1:0]           grp;
        logic [OC_W-1:0]                   out;
        logic [SEQ_W-1:0]                  seq;
        logic [PROBES-1:0]                 pv;
        logic [PROBES-1:0][VPN_W-1:0]      pvpn;
        logic [PROBES-1:0][NUM_PORTS-1:0]  pmask;
        logic [PROBES-1:0]                 pwr;
        logic [NUM_PORTS-1:0]              stall;
        logic                              rv;
        logic [PID_W-1:0]                  rp;
    } state_t;

    state_t d, q;

    logic [VPN_W-1:0]              vpn_in;
    logic [TS_W-1:0]               win_in;
    logic [OC_W-1:0]               slots;
    logic [NUM_GROUPS-1:0]         grp_vld;
    logic [NUM_GROUPS-1:0][KEY_W-1:0] grp_key;
    logic [NUM_GROUPS-1:0]         taken, cand_m, cand_f;
    logic [PROBES-1:0]             lane_vld;
    logic [PROBES-1:0][GI_W-1:0]   lane_idx;
    logic                          m_found, f_found;
    logic [GI_W-1:0]               m_idx, f_idx;
    logic                          accept, st_push, st_pop, st_ne;
    logic [PID_W-1:0]              st_head;
    logic [OC_W:0]                 issued;
    logic [OC_W-1:0]               outstanding;
    logic                          unused_lo;

    assign unused_lo = ^in_vaddr[PAGE_SHIFT-1:0];
    assign vpn_in    = in_vaddr[VA_W-1:PAGE_SHIFT];
    assign win_in    = TS_W'(in_time / WINDOW);
    assign slots     = OC_W'(MAX_OUT) - q.out;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cand
        assign grp_vld[g] = q.grp[g].vld;
        assign grp_key[g] = {q.grp[g].win, q.grp[g].seq};
        assign cand_f[g]  = !q.grp[g].vld;
        assign cand_m[g]  = q.grp[g].vld && !taken[g] && !merge_off &&
                            (q.grp[g].vpn == vpn_in) && (q.grp[g].win == win_in) &&
                            (q.grp[g].wr == acc_t'(in_write)) &&
                            (q.grp[g].cnt < DC_W'(GROUP_DEPTH));
    end

    xc_pick #(.N(NUM_GROUPS), .L(PROBES), .KW(KEY_W), .BW(OC_W)) u_pick (
        .elig(grp_vld), .key(grp_key), .budget(slots),
        .lane_vld(lane_vld), .lane_idx(lane_idx), .taken(taken)
    );

    xc_first #(.N(NUM_GROUPS)) u_match (.cand(cand_m), .found(m_found), .idx(m_idx));
    xc_first #(.N(NUM_GROUPS)) u_free  (.cand(cand_f), .found(f_found), .idx(f_idx));

    assign in_ready = m_found || f_found;
    assign accept   = in_valid && in_ready;
    assign st_push  = accept && (slots == '0) && !q.stall[in_port];
    assign st_pop   = st_ne && (slots != '0);

    xc_stall_fifo #(.DEPTH(NUM_PORTS), .W(PID_W)) u_stall (
        .clk(clk), .rst_n(rst_n), .push(st_push), .push_id(in_port),
        .pop(st_pop), .head(st_head), .nonempty(st_ne)
    );

    always_comb begin
        d      = q;
        issued = '0;
        for (int l = 0; l < PROBES; l++) begin
            d.pvpn[l]  = q.grp[lane_idx[l]].vpn;
            d.pmask[l] = lane_vld[l] ? q.grp[lane_idx[l]].mask : '0;
            d.pwr[l]   = q.grp[lane_idx[l]].wr;
            issued     = issued + (OC_W+1)'(lane_vld[l]);
        end
        d.pv = lane_vld;
        for (int i = 0; i < NUM_GROUPS; i++) begin
            if (taken[i]) d.grp[i].vld = 1'b0;
        end
        if (accept) begin
            if (m_found) begin
                d.grp[m_idx].mask[in_port] = 1'b1;
                d.grp[m_idx].cnt = q.grp[m_idx].cnt + 1'b1;
            end else begin
                d.grp[f_idx].vld  = 1'b1;
                d.grp[f_idx].wr   = acc_t'(in_write);
                d.grp[f_idx].vpn  = vpn_in;
                d.grp[f_idx].win  = win_in;
                d.grp[f_idx].seq  = q.seq;
                d.grp[f_idx].mask = '0;
                d.grp[f_idx].mask[in_port] = 1'b1;
                d.grp[f_idx].cnt  = DC_W'(1);
                d.seq = q.seq + 1'b1;
            end
        end
        d.out = OC_W'({1'b0, q.out} + issued - {1'b0, done_cnt});
        if (st_push) d.stall[in_port] = 1'b1;
        d.rv = st_pop;
        d.rp = st_pop ? st_head : '0;
        if (st_pop) d.stall[st_head] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign outstanding = q.out;
    assign pr_valid    = q.pv;
    assign pr_vpn      = q.pvpn;
    assign pr_mask     = q.pmask;
    assign pr_write    = q.pwr;
    assign stall_vec   = q.stall;
    assign rel_valid   = q.rv;
    assign rel_port    = q.rp;
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
    parameter int NUM_PORTS  = 8,
    parameter int PROBES     = 2,
    parameter int MAX_OUT    = 4,
    parameter int NUM_GROUPS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic                         in_ready,
    input logic [PROBES-1:0]            pr_valid,
    input logic [NUM_PORTS-1:0]         stall_vec,
    input logic                         rel_valid,
    input logic [$clog2(NUM_PORTS)-1:0] rel_port,
    input logic [$clog2(MAX_OUT+1)-1:0] outstanding,
    input logic [NUM_GROUPS-1:0]        grp_vld
);
    localparam int OC_W = $clog2(MAX_OUT + 1);

    logic [NUM_PORTS-1:0] stall_prev;
    logic [OC_W-1:0]      out_prev;
    logic                 sat_acc_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_prev   <= '0;
            out_prev     <= '0;
            sat_acc_prev <= 1'b0;
        end else begin
            stall_prev   <= stall_vec;
            out_prev     <= outstanding;
            sat_acc_prev <= in_valid && in_ready && (int'(outstanding) == MAX_OUT);
        end
    end

    AST_OUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= MAX_OUT); // R7

    AST_PROBE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pr_valid) <= (MAX_OUT - int'(out_prev))); // R7

    AST_LANE_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, pr_valid} + (PROBES+1)'(1)) & {1'b0, pr_valid}) == '0)); // R6

    AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> (&grp_vld)); // R8

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((stall_vec & ~stall_prev) != '0) |-> sat_acc_prev); // R9

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (stall_prev[rel_port] && !stall_vec[rel_port])); // R10
endmodule

bind xc_coalescer xc_checker #(
    .NUM_PORTS(NUM_PORTS), .PROBES(PROBES), .MAX_OUT(MAX_OUT), .NUM_GROUPS(NUM_GROUPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pr_valid(pr_valid), .stall_vec(stall_vec), .rel_valid(rel_valid),
    .rel_port(rel_port), .outstanding(outstanding), .grp_vld(grp_vld)
);

// File: tb/sim_xc_coalescer.sv
`timescale 1ns/1ps
module sim_xc_coalescer;
    localparam int NP = 8, VA_W = 32, PS = 12, TS_W = 16, P = 2, MO = 4;
    localparam int VPN_W = VA_W - PS;

    logic clk = 0, rst_n = 0, merge_off = 0, in_valid = 0, in_write = 0;
    logic [2:0] in_port = 0;
    logic [VA_W-1:0] in_vaddr = 0;
    logic [TS_W-1:0] in_time = 0;
    logic [2:0] done_cnt = 0;
    logic in_ready, rel_valid;
    logic [P-1:0] pr_valid, pr_write;
    logic [P*VPN_W-1:0] pr_vpn;
    logic [P*NP-1:0] pr_mask;
    logic [NP-1:0] stall_vec;
    logic [2:0] rel_port;

    xc_coalescer u0 (.*);

    always #2.5 clk = ~clk;

    typedef struct { int vpn; int mask; int wr; } exp_t;
    exp_t expq[$];
    int rel_seen[$];
    int checks = 0, errors = 0, seen = 0, done_total = 0, max_lanes = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: pops expected probes in lane order
    always @(negedge clk) begin
        if (rst_n) begin
            int n;
            n = 0;
            for (int l = 0; l < P; l++) begin
                if (pr_valid[l]) begin
                    n++;
                    seen++;
                    if (expq.size() == 0) begin
                        chk(0, "R6", "unexpected probe vpn", pr_vpn[l*VPN_W +: VPN_W], 0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(pr_vpn[l*VPN_W +: VPN_W] == VPN_W'(e.vpn) &&
                            pr_mask[l*NP +: NP] == NP'(e.mask) && pr_write[l] == e.wr[0],
                            "R2", "probe {vpn,mask,wr}",
                            {pr_vpn[l*VPN_W +: VPN_W], pr_mask[l*NP +: NP], 3'b0, pr_write[l]},
                            {VPN_W'(e.vpn), NP'(e.mask), 3'b0, e.wr[0]});
                    end
                end
            end
            if (n > max_lanes) max_lanes = n;
            if (rel_valid) rel_seen.push_back(int'(rel_port));
        end
    end

    task automatic expect_probe(input int vpn, input int mask, input int wr);
        exp_t e;
        e.vpn = vpn; e.mask = mask; e.wr = wr;
        expq.push_back(e);
    endtask

    task automatic send(input int port, input int va, input int t, input int wr,
                        input bit want_ready, input string req);
        @(negedge clk);
        in_valid = 1; in_port = 3'(port); in_vaddr = VA_W'(va);
        in_time = TS_W'(t); in_write = wr[0];
        #1;
        chk(in_ready == want_ready, req, "in_ready", in_ready, want_ready);
        if (in_ready) begin
            @(posedge clk);
            #1;
        end
        in_valid = 0;
    endtask

    task automatic complete(input int n);
        @(negedge clk);
        done_cnt = 3'(n);
        done_total += n;
        @(negedge clk);
        done_cnt = 0;
    endtask

    task automatic wait_drain(input string req);
        for (int i = 0; i < 60 && expq.size() != 0; i++) @(negedge clk);
        chk(expq.size() == 0, req, "pending expected probes", expq.size(), 0);
    endtask

    task automatic drain_all();
        for (int k = 0; k < 6; k++) begin
            repeat (4) @(negedge clk);
            if (seen > done_total) complete(seen - done_total);
        end
    endtask

    task automatic saturate();
        for (int k = 0; k < MO; k++) expect_probe(32'h100 + k, 8'h80, 0);
        for (int k = 0; k < MO; k++) send(7, (32'h100 + k) << PS, 0, 0, 1, "R7");
        wait_drain("R7");
        chk(seen - done_total == MO, "R7", "outstanding after saturation", seen - done_total, MO);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
        chk(pr_valid == 0, "R1", "pr_valid", pr_valid, 0);
        chk(stall_vec == 0 && rel_valid == 0, "R1", "stall/rel", {stall_vec, rel_valid}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // single write request
        expect_probe(32'h12, 8'h01, 1);
        send(0, 32'h12345, 4, 1, 1, "R2");
        wait_drain("R2");
        complete(1);

        // merging, window ordering, stall queue
        saturate();
        rel_seen.delete();
        send(1, 32'h2A123, 3, 0, 1, "R9");
        send(2, 32'h2A7FF, 3, 0, 1, "R2");
        send(1, 32'h2A000, 3, 0, 1, "R9");
        send(3, 32'h2A010, 5, 0, 1, "R3");
        send(4, 32'h2A020, 3, 1, 1, "R3");
        send(5, 32'h3B000, 2, 0, 1, "R6");
        chk(stall_vec == 8'h3E, "R9", "stall_vec", stall_vec, 8'h3E);
        chk(pr_valid == 0, "R7", "no probe without credit", pr_valid, 0);
        expect_probe(32'h3B, 8'h20, 0);
        expect_probe(32'h2A, 8'h06, 0);
        expect_probe(32'h2A, 8'h10, 1);
        expect_probe(32'h2A, 8'h08, 0);
        complete(4);
        wait_drain("R6");
        chk(max_lanes == P, "R7", "max probes in one cycle", max_lanes, P);
        drain_all();
        chk(rel_seen.size() == 5, "R10", "release count", rel_seen.size(), 5);
        for (int k = 0; k < 5 && k < rel_seen.size(); k++)
            chk(rel_seen[k] == k + 1, "R10", "release order", rel_seen[k], k + 1);
        chk(stall_vec == 0, "R10", "stall_vec after release", stall_vec, 0);

        // group capacity
        saturate();
        for (int k = 0; k < 5; k++) send(k, 32'h55000 + k, 7, 0, 1, "R5");
        expect_probe(32'h55, 8'h0F, 0);
        expect_probe(32'h55, 8'h10, 0);
        complete(4);
        wait_drain("R5");
        drain_all();
        chk(stall_vec == 0, "R10", "stall_vec after capacity", stall_vec, 0);

        // full table back-pressure, merge into full table
        saturate();
        for (int k = 0; k < 8; k++) send(6, (32'h60 + k) << PS, 9, 0, 1, "R8");
        send(6, 32'h70 << PS, 9, 0, 0, "R8");
        send(5, 32'h63 << PS, 9, 0, 1, "R8");
        for (int k = 0; k < 8; k++) expect_probe(32'h60 + k, (k == 3) ? 8'h60 : 8'h40, 0);
        complete(4);
        drain_all();
        wait_drain("R6");

        // merging disabled
        saturate();
        merge_off = 1;
        send(2, 32'h77000, 1, 0, 1, "R4");
        send(3, 32'h77008, 1, 0, 1, "R4");
        merge_off = 0;
        expect_probe(32'h77, 8'h04, 0);
        expect_probe(32'h77, 8'h08, 0);
        complete(4);
        wait_drain("R4");
        drain_all();
        chk(seen == done_total, "R7", "outstanding at end", seen - done_total, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule